// File: doc/BRIEF.md
# Pad Function Multiplexer with Debug Lock

This block connects a handful of package pads to the signals of on-chip peripherals. Every pad owns a function-ID register, written through a small register port. The ID chooses one peripheral signal for the pad. That signal also sets the pad's direction: an output signal drives the pad's output value with the output enable asserted, and an input signal takes the pad's level back into the peripheral. IDs are split into two groups. The low group gives each pad one fixed, dedicated connection. The upper group forms a full crossbar, in which any pad may carry any signal of the UART or the SPI master.

Two pads, the debug clock pad and the debug data pad, leave reset assigned to the serial-wire debug function and locked there. A write to a locked pad's register is dropped and raises a sticky error flag. Software has to clear the debug-enable bit before either pad can take another function. Each time a debug pad is moved to a non-debug function, the block pulses a report that names the pad and the new ID. This makes the loss of debug access visible.

Pad outputs and peripheral inputs are registered, so each takes effect one clock after its cause. When no pad selects a peripheral input, that input holds a defined idle level. When several pads select the same input, the pad with the lowest index drives it.

Top module: `pad_fn_mux`

## Requirements
- R1: After reset, the debug clock pad (index 2) and the debug data pad (index 3) hold ID 2, all other pads hold ID 0, the debug-enable bit is 1, the error bit is 0, and pads 0 to 2 have their output enable low.
- R2: ID 0, any ID from 3 to 18, any ID of 25 or more, and ID 2 on a pad that is not a debug pad all leave the pad's output enable low.
- R3: ID 1 selects each pad's dedicated signal: pad 0 is UART receive (input), pad 1 is UART transmit (output), pad 2 is SPI clock (output), pad 3 is SPI data-in (input).
- R4: IDs 19 to 24 select, on any pad and in this order: UART transmit, UART receive, SPI clock, SPI data-out, SPI data-in, SPI chip-select. The output signals drive the pad with the output enable high.
- R5: A pad's output value and output enable follow a change of its ID or of the selected peripheral output one clock later. Peripheral inputs follow the pad level one clock later.
- R6: A peripheral input that no pad selects reads its idle level: 1 for UART receive, and 0 for SPI data-in, debug clock and debug data-in.
- R7: When several pads select the same peripheral input, the lowest-numbered pad drives it.
- R8: While debug is enabled, a write to either debug pad's register leaves that register unchanged and sets the error bit. The error bit stays set until a control write with bit 1 high clears it.
- R9: The control register sits at address 4. Bit 0 is debug enable and bit 1 is the error flag. Writing 0 to bit 0 unlocks the debug pads. Writing 1 to bit 0 while unlocked re-locks them and returns both debug pads to ID 2.
- R10: An accepted write of an ID other than 2 to a debug pad gives a one-cycle report pulse, with the pad index and the written ID on the report outputs.
- R11: Under ID 2, the debug clock pad feeds the debug clock input. The debug data pad is driven by the debug data output and its enable, and its level returns on the debug data input.
- R12: Read data appears one clock after the read address is presented. Addresses 0 to 3 return the pad IDs and address 4 returns the error bit and the enable bit in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0-3 pad IDs, 4 control) |
| wr_data | input | 6 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 6 | Registered read data |
| pad_i | input | 4 | Level seen at each pad |
| pad_o | output | 4 | Value driven to each pad |
| pad_oe | output | 4 | Output enable per pad |
| uart_tx | input | 1 | UART transmit from the peripheral |
| uart_rx | output | 1 | UART receive to the peripheral |
| spi_sck | input | 1 | SPI clock from the peripheral |
| spi_mosi | input | 1 | SPI data-out from the peripheral |
| spi_cs_n | input | 1 | SPI chip-select from the peripheral |
| spi_miso | output | 1 | SPI data-in to the peripheral |
| dbg_clk | output | 1 | Debug clock to the debug port |
| dbg_dio_o | input | 1 | Debug data output from the debug port |
| dbg_dio_oe | input | 1 | Debug data output enable from the debug port |
| dbg_dio_i | output | 1 | Debug data input to the debug port |
| lost_vld | output | 1 | One-cycle pulse: a debug pad has been reassigned |
| lost_pad | output | 2 | Index of the reassigned debug pad |
| lost_fid | output | 6 | ID written to that pad |

## Verification
The hardest condition to reach from the ports is a debug pad carrying a non-debug function. The stimulus has to clear the debug-enable bit first, and every attempt made before that must be rejected and must leave its trace in the sticky flag. The bench drives this in a fixed order. It makes locked writes, checks the rejection and the error flag through the read port, clears the flag, releases the lock, reassigns a debug pad and catches the report pulse, then re-locks and reads back the restored IDs. After that, a seeded random phase writes IDs from all ranges to all four pads, including the debug pads while unlocked. It compares every pad output and every peripheral input against a model built from the ID tables.

// File: rtl/pad_fn_mux_pkg.sv
package pad_fn_mux_pkg;

  localparam int FID_DED     = 1;
  localparam int FID_DBG     = 2;
  localparam int FID_XB_BASE = 19;
  localparam int XB_COUNT    = 6;

  typedef enum logic [3:0] {
    SIG_NONE,
    SIG_UART_TX,
    SIG_UART_RX,
    SIG_SPI_SCK,
    SIG_SPI_MOSI,
    SIG_SPI_MISO,
    SIG_SPI_CS,
    SIG_DBG_CLK,
    SIG_DBG_DIO
  } pad_sig_e;

  // fixed connection of each pad under the dedicated ID
  function automatic pad_sig_e ded_sig(input int pad);
    case (pad % 4)
      0:       return SIG_UART_RX;
      1:       return SIG_UART_TX;
      2:       return SIG_SPI_SCK;
      default: return SIG_SPI_MISO;
    endcase
  endfunction

  function automatic pad_sig_e fid_decode(input int fid, input int pad,
                                          input bit clk_pad, input bit dat_pad);
    if (fid == FID_DBG) begin
      if (clk_pad) return SIG_DBG_CLK;
      if (dat_pad) return SIG_DBG_DIO;
      return SIG_NONE;
    end
    if (fid == FID_DED) return ded_sig(pad);
    if (fid >= FID_XB_BASE && fid < FID_XB_BASE + XB_COUNT) begin
      case (fid - FID_XB_BASE)
        0:       return SIG_UART_TX;
        1:       return SIG_UART_RX;
        2:       return SIG_SPI_SCK;
        3:       return SIG_SPI_MOSI;
        4:       return SIG_SPI_MISO;
        default: return SIG_SPI_CS;
      endcase
    end
    return SIG_NONE;
  endfunction

endpackage

// File: rtl/pad_fn_mux_cfg.sv
module pad_fn_mux_cfg #(
  parameter int NPADS   = 4,
  parameter int FID_W   = 6,
  parameter int CLK_PAD = 2,
  parameter int DAT_PAD = 3,
  localparam int AW     = $clog2(NPADS + 1),
  localparam int PAD_W  = $clog2(NPADS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [FID_W-1:0]             wr_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [FID_W-1:0]             rd_data,
  output logic [NPADS-1:0][FID_W-1:0]  fid_o,
  output logic                         lost_vld,
  output logic [PAD_W-1:0]             lost_pad,
  output logic [FID_W-1:0]             lost_fid
);
  import pad_fn_mux_pkg::*;

  localparam logic [AW-1:0]    CTRL_ADDR = AW'(NPADS);
  localparam logic [FID_W-1:0] DBG_ID    = FID_W'(FID_DBG);

  logic [NPADS-1:0][FID_W-1:0] fid_q;
  logic dbg_en_q, err_q;
  logic wr_pad, wr_is_dbg;

  assign wr_pad    = wr_addr < CTRL_ADDR;
  assign wr_is_dbg = (wr_addr == AW'(CLK_PAD)) || (wr_addr == AW'(DAT_PAD));
  assign fid_o     = fid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPADS; p++)
        fid_q[p] <= (p == CLK_PAD || p == DAT_PAD) ? DBG_ID : '0;
      dbg_en_q <= 1'b1;
      err_q    <= 1'b0;
      lost_vld <= 1'b0;
      lost_pad <= '0;
      lost_fid <= '0;
      rd_data  <= '0;
    end else begin
      lost_vld <= 1'b0;
      if (wr_en && wr_pad) begin
        if (wr_is_dbg && dbg_en_q) begin
          err_q <= 1'b1;
        end else begin
          fid_q[wr_addr[PAD_W-1:0]] <= wr_data;
          if (wr_is_dbg && wr_data != DBG_ID) begin
            lost_vld <= 1'b1;
            lost_pad <= wr_addr[PAD_W-1:0];
            lost_fid <= wr_data;
          end
        end
      end else if (wr_en && wr_addr == CTRL_ADDR) begin
        dbg_en_q <= wr_data[0];
        if (wr_data[0] && !dbg_en_q) begin
          fid_q[CLK_PAD] <= DBG_ID;
          fid_q[DAT_PAD] <= DBG_ID;
        end
        if (wr_data[1]) err_q <= 1'b0;
      end
      if (rd_addr < CTRL_ADDR)       rd_data <= fid_q[rd_addr[PAD_W-1:0]];
      else if (rd_addr == CTRL_ADDR) rd_data <= FID_W'({err_q, dbg_en_q});
      else                           rd_data <= '0;
    end
  end

  // R8
  locked_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_is_dbg && dbg_en_q) |=> ($stable(fid_q) && err_q));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_en && wr_addr == CTRL_ADDR && wr_data[1])) |=> err_q);

  // R9
  lock_holds_dbg_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_en_q |-> (fid_q[CLK_PAD] == DBG_ID && fid_q[DAT_PAD] == DBG_ID));

  // R10
  lost_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    lost_vld |-> (!dbg_en_q && lost_fid != DBG_ID));

endmodule

// File: rtl/pad_fn_mux_out.sv
module pad_fn_mux_out #(
  parameter int NPADS = 4,
  parameter int FID_W = 6
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  pad_fn_mux_pkg::pad_sig_e [NPADS-1:0]   sig_i,
  input  logic [NPADS-1:0][FID_W-1:0]            fid_i,
  input  logic                                   uart_tx,
  input  logic                                   spi_sck,
  input  logic                                   spi_mosi,
  input  logic                                   spi_cs_n,
  input  logic                                   dbg_dio_o,
  input  logic                                   dbg_dio_oe,
  output logic [NPADS-1:0]                       pad_o,
  output logic [NPADS-1:0]                       pad_oe
);
  import pad_fn_mux_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= '0;
      pad_oe <= '0;
    end else begin
      for (int p = 0; p < NPADS; p++) begin
        case (sig_i[p])
          SIG_UART_TX:  begin pad_o[p] <= uart_tx;   pad_oe[p] <= 1'b1;       end
          SIG_SPI_SCK:  begin pad_o[p] <= spi_sck;   pad_oe[p] <= 1'b1;       end
          SIG_SPI_MOSI: begin pad_o[p] <= spi_mosi;  pad_oe[p] <= 1'b1;       end
          SIG_SPI_CS:   begin pad_o[p] <= spi_cs_n;  pad_oe[p] <= 1'b1;       end
          SIG_DBG_DIO:  begin pad_o[p] <= dbg_dio_o; pad_oe[p] <= dbg_dio_oe; end
          default:      begin pad_o[p] <= 1'b0;      pad_oe[p] <= 1'b0;       end
        endcase
      end
    end
  end

  for (genvar g = 0; g < NPADS; g++) begin : g_chk
    // R2
    parked_hiz_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(fid_i[g]) == '0) |-> !pad_oe[g]);
  end

endmodule

// File: rtl/pad_fn_mux_in.sv
module pad_fn_mux_in #(
  parameter int NPADS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  pad_fn_mux_pkg::pad_sig_e [NPADS-1:0] sig_i,
  input  logic [NPADS-1:0]                     pad_i,
  output logic                                 uart_rx,
  output logic                                 spi_miso,
  output logic                                 dbg_clk,
  output logic                                 dbg_dio_i
);
  import pad_fn_mux_pkg::*;

  logic rx_n, miso_n, dclk_n, dio_n;

  // scan from the top so the lowest pad is applied last and wins
  always_comb begin
    rx_n = 1'b1; miso_n = 1'b0; dclk_n = 1'b0; dio_n = 1'b0;
    for (int p = NPADS - 1; p >= 0; p--) begin
      case (sig_i[p])
        SIG_UART_RX:  rx_n   = pad_i[p];
        SIG_SPI_MISO: miso_n = pad_i[p];
        SIG_DBG_CLK:  dclk_n = pad_i[p];
        SIG_DBG_DIO:  dio_n  = pad_i[p];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uart_rx <= 1'b1; spi_miso <= 1'b0; dbg_clk <= 1'b0; dbg_dio_i <= 1'b0;
    end else begin
      uart_rx <= rx_n; spi_miso <= miso_n; dbg_clk <= dclk_n; dbg_dio_i <= dio_n;
    end
  end

  // R6
  rx_idle_rst_chk: assert property (@(posedge clk) rst |=> uart_rx);

endmodule

// File: rtl/pad_fn_mux.sv
module pad_fn_mux #(
  parameter int NPADS   = 4,
  parameter int FID_W   = 6,
  parameter int CLK_PAD = 2,
  parameter int DAT_PAD = 3,
  localparam int AW     = $clog2(NPADS + 1),
  localparam int PAD_W  = $clog2(NPADS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [FID_W-1:0]  wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [FID_W-1:0]  rd_data,
  input  logic [NPADS-1:0]  pad_i,
  output logic [NPADS-1:0]  pad_o,
  output logic [NPADS-1:0]  pad_oe,
  input  logic              uart_tx,
  output logic              uart_rx,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              dbg_clk,
  input  logic              dbg_dio_o,
  input  logic              dbg_dio_oe,
  output logic              dbg_dio_i,
  output logic              lost_vld,
  output logic [PAD_W-1:0]  lost_pad,
  output logic [FID_W-1:0]  lost_fid
);
  import pad_fn_mux_pkg::*;

  logic [NPADS-1:0][FID_W-1:0] fid;
  pad_sig_e [NPADS-1:0]        sig;

  pad_fn_mux_cfg #(.NPADS(NPADS), .FID_W(FID_W), .CLK_PAD(CLK_PAD), .DAT_PAD(DAT_PAD)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fid_o(fid),
    .lost_vld(lost_vld), .lost_pad(lost_pad), .lost_fid(lost_fid));

  for (genvar p = 0; p < NPADS; p++) begin : g_dec
    assign sig[p] = fid_decode(int'(fid[p]), p, p == CLK_PAD, p == DAT_PAD);
  end

  pad_fn_mux_out #(.NPADS(NPADS), .FID_W(FID_W)) u_out (
    .clk(clk), .rst(rst), .sig_i(sig), .fid_i(fid),
    .uart_tx(uart_tx), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .dbg_dio_o(dbg_dio_o), .dbg_dio_oe(dbg_dio_oe), .pad_o(pad_o), .pad_oe(pad_oe));

  pad_fn_mux_in #(.NPADS(NPADS)) u_in (
    .clk(clk), .rst(rst), .sig_i(sig), .pad_i(pad_i),
    .uart_rx(uart_rx), .spi_miso(spi_miso), .dbg_clk(dbg_clk), .dbg_dio_i(dbg_dio_i));

endmodule

// File: tb/tb_pad_fn_mux.sv
module tb_pad_fn_mux;
  localparam int NP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [5:0] wr_data = '0;
  logic [5:0] rd_data;
  logic [NP-1:0] pad_i = '0, pad_o, pad_oe;
  logic uart_tx = 0, spi_sck = 0, spi_mosi = 0, spi_cs_n = 0, dbg_dio_o = 0, dbg_dio_oe = 0;
  logic uart_rx, spi_miso, dbg_clk, dbg_dio_i, lost_vld;
  logic [1:0] lost_pad;
  logic [5:0] lost_fid;

  int n_chk = 0, n_fail = 0;
  int fidm [NP];

  always #2 clk = ~clk;

  pad_fn_mux dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 6'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_addr = 3'(a);
    @(negedge clk); v = int'(rd_data);
  endtask

  // signal codes: 0 none,1 tx,2 rx,3 sck,4 mosi,5 miso,6 cs,7 dclk,8 dio
  function automatic int sig_of(input int p, input int f);
    if (f == 2) return (p == 2) ? 7 : (p == 3) ? 8 : 0;
    if (f == 1) begin
      case (p) 0: return 2; 1: return 1; 2: return 3; default: return 5; endcase
    end
    if (f >= 19 && f <= 24) return f - 18;
    return 0;
  endfunction

  task automatic expect_all(input string req);
    logic [NP-1:0] eo, eoe;
    logic erx, emiso, edclk, edio;
    eo = '0; eoe = '0; erx = 1; emiso = 0; edclk = 0; edio = 0;
    for (int p = 0; p < NP; p++) begin
      case (sig_of(p, fidm[p]))
        1: begin eo[p] = uart_tx;   eoe[p] = 1; end
        3: begin eo[p] = spi_sck;   eoe[p] = 1; end
        4: begin eo[p] = spi_mosi;  eoe[p] = 1; end
        6: begin eo[p] = spi_cs_n;  eoe[p] = 1; end
        8: begin eo[p] = dbg_dio_o; eoe[p] = dbg_dio_oe; end
        default: ;
      endcase
    end
    for (int p = NP - 1; p >= 0; p--) begin
      case (sig_of(p, fidm[p]))
        2: erx = pad_i[p];
        5: emiso = pad_i[p];
        7: edclk = pad_i[p];
        8: edio = pad_i[p];
        default: ;
      endcase
    end
    chk({pad_oe, pad_o} == {eoe, eo}, {req, " pads"}, int'({pad_oe, pad_o}), int'({eoe, eo}));
    chk({uart_rx, spi_miso, dbg_clk, dbg_dio_i} == {erx, emiso, edclk, edio},
        {req, " inputs"}, int'({uart_rx, spi_miso, dbg_clk, dbg_dio_i}),
        int'({erx, emiso, edclk, edio}));
  endtask

  task automatic setf(input int p, input int f);
    wr(p, f); fidm[p] = f;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    fidm = '{0, 0, 2, 2};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk(v == 0, "R1 pad0 id", v, 0);
    rd(2, v); chk(v == 2, "R1 pad2 id", v, 2);
    rd(3, v); chk(v == 2, "R1 pad3 id", v, 2);
    rd(4, v); chk(v == 1, "R1 ctrl", v, 1);
    chk(pad_oe[2:0] == 3'b000, "R1 oe", int'(pad_oe), 0);
    expect_all("R6 idle at reset");

    // R11 debug pads
    dbg_dio_o = 1; dbg_dio_oe = 1; pad_i = 4'b1100;
    repeat (2) @(negedge clk);
    expect_all("R11 debug route");
    chk(dbg_clk == 1 && dbg_dio_i == 1 && pad_oe[3] && pad_o[3], "R11 debug", int'({dbg_clk, dbg_dio_i}), 3);

    // R3 dedicated IDs
    setf(0, 1); setf(1, 1); uart_tx = 1; pad_i = 4'b0000;
    repeat (2) @(negedge clk);
    expect_all("R3 dedicated");
    chk(uart_rx == 0 && pad_oe[1] && pad_o[1], "R3 uart", int'({uart_rx, pad_oe[1]}), 1);

    // R5 latency: output follows one clock after peripheral change
    @(negedge clk); uart_tx = 0; #1;
    chk(pad_o[1] == 1, "R5 before edge", int'(pad_o[1]), 1);
    @(negedge clk);
    chk(pad_o[1] == 0, "R5 after one edge", int'(pad_o[1]), 0);

    // R2 unassigned
    setf(0, 25); setf(1, 2);
    repeat (2) @(negedge clk);
    chk(pad_oe[1:0] == 2'b00, "R2 unassigned oe", int'(pad_oe), 0);
    setf(0, 7); setf(1, 0);
    repeat (2) @(negedge clk);
    chk(pad_oe[1:0] == 2'b00, "R2 gap id oe", int'(pad_oe), 0);
    chk(uart_rx == 1, "R6 rx idle", int'(uart_rx), 1);

    // R7 priority
    setf(0, 20); setf(1, 20); pad_i = 4'b0010;
    repeat (2) @(negedge clk);
    chk(uart_rx == 0, "R7 lowest pad wins", int'(uart_rx), 0);
    pad_i = 4'b0001;
    repeat (2) @(negedge clk);
    chk(uart_rx == 1, "R7 lowest pad wins", int'(uart_rx), 1);

    // R8 locked write ignored, sticky error
    wr(2, 19);
    chk(lost_vld == 0, "R10 no report when locked", int'(lost_vld), 0);
    rd(2, v); chk(v == 2, "R8 locked id kept", v, 2);
    rd(4, v); chk(v == 3, "R8 error set", v, 3);
    wr(4, 1);
    rd(4, v); chk(v == 3, "R8 error sticky", v, 3);
    wr(4, 3);
    rd(4, v); chk(v == 1, "R8 error cleared", v, 1);

    // R9 release, R10 report
    wr(4, 0);
    rd(4, v); chk(v == 0, "R9 released", v, 0);
    wr(3, 19); fidm[3] = 19;
    chk(lost_vld == 1 && lost_pad == 3 && lost_fid == 19, "R10 report",
        int'({lost_vld, lost_pad, lost_fid}), int'({1'b1, 2'd3, 6'd19}));
    @(negedge clk);
    chk(lost_vld == 0, "R10 one-cycle pulse", int'(lost_vld), 0);
    rd(3, v); chk(v == 19, "R12 readback", v, 19);
    expect_all("R4 debug pad crossbar");
    rd(4, v); chk(v == 0, "R8 no error when unlocked", v, 0);

    // R9 re-lock restores
    wr(4, 1); fidm[2] = 2; fidm[3] = 2;
    rd(2, v); chk(v == 2, "R9 relock pad2", v, 2);
    rd(3, v); chk(v == 2, "R9 relock pad3", v, 2);
    repeat (2) @(negedge clk);
    expect_all("R9 relocked routing");

    // R4 random configurations, unlocked
    wr(4, 0);
    for (int it = 0; it < 150; it++) begin
      for (int p = 0; p < NP; p++) begin
        int r, f;
        r = int'($urandom_range(0, 9));
        f = (r < 5) ? int'($urandom_range(19, 24)) : (r < 7) ? int'($urandom_range(0, 2))
                    : int'($urandom_range(0, 63));
        setf(p, f);
      end
      {uart_tx, spi_sck, spi_mosi, spi_cs_n, dbg_dio_o, dbg_dio_oe} = 6'($urandom);
      pad_i = 4'($urandom);
      repeat (2) @(negedge clk);
      expect_all("R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule